// File: doc/BRIEF.md
# OTP Fuse Word Read Sequencer

This engine fetches a run of consecutive 32-bit words from a one-time-programmable fuse macro. It drives the macro's control pins itself, so software only supplies a starting word index and a word count, then pulses `start`. The engine first checks the request against the configured fuse count. It then wakes the macro in a fixed order and produces one slow, timed clock pulse per word. Each captured word is handed over on a valid/ready stream. After the last word it puts the macro back to sleep in the reverse order.

All waits are counted in system clock cycles. Each wait is derived from a microsecond figure multiplied by a clocks-per-microsecond parameter. A request that is out of range, or that asks for no words, finishes at once and leaves the macro pins alone.

Top module: `fuse_rd_seq`

## Requirements
- R1: A start with `req_idx >= TOTAL_FUSES` or `req_idx + req_cnt > TOTAL_FUSES` is rejected. One cycle after start, `done` and `err` are both high for one cycle and `busy` stays low. The macro pins (`otp_stby_n`, `otp_trim`, `otp_ce`, `otp_clk`, `otp_addr`) do not change.
- R2: An in-range start with `req_cnt == 0` gives a one-cycle `done` with `err` low, one cycle after start. There is no macro pin activity and `busy` stays low.
- R3: For an accepted request, the wake-up runs on three successive clock cycles in this order: `otp_stby_n` rises (1 means awake), then `otp_trim` rises, then `otp_ce` rises. Trim is never high without standby released, and chip-enable is never high without trim.
- R4: For each word, `otp_addr` carries the word index for at least one cycle before `otp_clk` rises. The address stays stable while `otp_clk` is high. `otp_clk` stays high for exactly `T_ACC_US*CLKS_PER_US` cycles and is high only while `otp_ce` is high.
- R5: After the high phase, `otp_clk` stays low for `T_LOW_US*CLKS_PER_US` cycles. On the next edge, `otp_dout` is captured and presented on `out_data` with `out_valid` high.
- R6: Words are read from addresses `req_idx`, `req_idx+1`, and so on. Exactly `req_cnt` words are delivered, in address order.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. No new macro clock pulse starts and `otp_addr` does not move.
- R8: After the last word is accepted, power-down runs on three successive cycles: `otp_ce` falls, then `otp_trim` falls, then `otp_stby_n` falls. `done` is high in the cycle in which `otp_stby_n` is first seen low.
- R9: `busy` is high from the cycle after an accepted start until power-down completes. `done` is a single-cycle pulse with `busy` low. A start while `busy` is high has no effect on the addresses or the word count.
- R10: After reset, all macro pins, `busy`, `done`, `err` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse |
| req_idx | input | 13 | First word index |
| req_cnt | input | 13 | Number of words |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (with done) |
| out_valid | output | 1 | Word available |
| out_ready | input | 1 | Consumer accepts word |
| out_data | output | 32 | Word value |
| otp_addr | output | 12 | Macro word address |
| otp_clk | output | 1 | Macro read clock |
| otp_ce | output | 1 | Macro chip enable |
| otp_trim | output | 1 | Macro trim/repair enable |
| otp_stby_n | output | 1 | Standby release (1 = awake) |
| otp_dout | input | 32 | Macro data output |

## Verification
A new start can arrive while the sequencer is partway through a timed macro clock pulse. In that cycle the request-capture logic and the per-word timing both have a claim on the address and count registers. The bench raises `start` with a different index while `otp_clk` is high. It then judges the outcome at the pins: every macro clock rise must still show the next address of the original run, and the delivered word count must equal the original request. A consumer stall is also placed on a middle word. This confirms that the next clock pulse waits for the handshake and does not run on into it.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_TRIM,
        ST_PU_CE,
        ST_ADDR,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_PUSH,
        ST_PD_TRIM,
        ST_PD_STBY
    } seq_state_e;

    typedef enum logic [1:0] {
        REQ_OK,
        REQ_EMPTY,
        REQ_RANGE
    } req_verdict_e;

    typedef struct packed {
        logic stby_n;
        logic trim;
        logic ce;
        logic clk;
    } macro_ctl_t;

    function automatic int unsigned us_to_clks(input int unsigned us, input int unsigned cpu);
        return us * cpu;
    endfunction

endpackage

// File: rtl/fuse_rd_reqchk.sv
module fuse_rd_reqchk
    import fuse_rd_pkg::*;
#(
    parameter int CNT_W  = 13,
    parameter int TOTAL  = 4096
) (
    input  logic [CNT_W-1:0] idx,
    input  logic [CNT_W-1:0] cnt,
    output req_verdict_e     verdict
);
    logic [CNT_W:0] span_end;

    always_comb begin
        span_end = {1'b0, idx} + {1'b0, cnt};
        if (idx >= CNT_W'(TOTAL) || span_end > (CNT_W+1)'(TOTAL))
            verdict = REQ_RANGE;
        else if (cnt == '0)
            verdict = REQ_EMPTY;
        else
            verdict = REQ_OK;
    end
endmodule

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - TMR_W'(1);
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
    import fuse_rd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 13,
    parameter int TMR_W  = 8,
    parameter int HI_CYC = 40,
    parameter int LO_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  req_idx,
    input  logic [CNT_W-1:0]  req_cnt,
    input  req_verdict_e      verdict,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output macro_ctl_t        ctl,
    output logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] dout
);
    seq_state_e        state_q;
    macro_ctl_t        ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic [WORD_W-1:0] data_q;
    logic              valid_q;
    logic              done_q;
    logic              err_q;

    always_comb begin
        tmr_load = (state_q == ST_ADDR) || (state_q == ST_CLK_HI && tmr_zero);
        tmr_val  = (state_q == ST_ADDR) ? TMR_W'(HI_CYC - 1) : TMR_W'(LO_CYC - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        case (verdict)
                            REQ_RANGE: begin
                                done_q <= 1'b1;
                                err_q  <= 1'b1;
                            end
                            REQ_EMPTY: done_q <= 1'b1;
                            default: begin
                                ctl_q.stby_n <= 1'b1;
                                addr_q       <= req_idx[ADDR_W-1:0];
                                left_q       <= req_cnt;
                                state_q      <= ST_PU_TRIM;
                            end
                        endcase
                    end
                end
                ST_PU_TRIM: begin
                    ctl_q.trim <= 1'b1;
                    state_q    <= ST_PU_CE;
                end
                ST_PU_CE: begin
                    ctl_q.ce <= 1'b1;
                    state_q  <= ST_ADDR;
                end
                ST_ADDR: begin
                    ctl_q.clk <= 1'b1;
                    state_q   <= ST_CLK_HI;
                end
                ST_CLK_HI: begin
                    if (tmr_zero) begin
                        ctl_q.clk <= 1'b0;
                        state_q   <= ST_CLK_LO;
                    end
                end
                ST_CLK_LO: begin
                    if (tmr_zero) begin
                        data_q  <= dout;
                        valid_q <= 1'b1;
                        state_q <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (out_ready) begin
                        valid_q <= 1'b0;
                        left_q  <= left_q - CNT_W'(1);
                        if (left_q == CNT_W'(1)) begin
                            ctl_q.ce <= 1'b0;
                            state_q  <= ST_PD_TRIM;
                        end else begin
                            addr_q  <= addr_q + ADDR_W'(1);
                            state_q <= ST_ADDR;
                        end
                    end
                end
                ST_PD_TRIM: begin
                    ctl_q.trim <= 1'b0;
                    state_q    <= ST_PD_STBY;
                end
                ST_PD_STBY: begin
                    ctl_q.stby_n <= 1'b0;
                    done_q       <= 1'b1;
                    state_q      <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign done      = done_q;
    assign err       = err_q;
    assign out_valid = valid_q;
    assign out_data  = data_q;
    assign ctl       = ctl_q;
    assign addr      = addr_q;
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int TOTAL_FUSES = 4096,
    parameter int CLKS_PER_US = 10,
    parameter int T_ACC_US    = 40,
    parameter int T_LOW_US    = 10,
    localparam int CNT_W      = $clog2(TOTAL_FUSES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  req_idx,
    input  logic [CNT_W-1:0]  req_cnt,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic [ADDR_W-1:0] otp_addr,
    output logic              otp_clk,
    output logic              otp_ce,
    output logic              otp_trim,
    output logic              otp_stby_n,
    input  logic [WORD_W-1:0] otp_dout
);
    localparam int HI_CYC = us_to_clks(T_ACC_US, CLKS_PER_US);
    localparam int LO_CYC = us_to_clks(T_LOW_US, CLKS_PER_US);
    localparam int MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int TMR_W  = $clog2(MAX_CYC + 1);

    req_verdict_e     verdict;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    macro_ctl_t       ctl;

    fuse_rd_reqchk #(.CNT_W(CNT_W), .TOTAL(TOTAL_FUSES)) u_reqchk (
        .idx     (req_idx),
        .cnt     (req_cnt),
        .verdict (verdict)
    );

    fuse_rd_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    fuse_rd_fsm #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .TMR_W  (TMR_W),
        .HI_CYC (HI_CYC),
        .LO_CYC (LO_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .req_idx   (req_idx),
        .req_cnt   (req_cnt),
        .verdict   (verdict),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .ctl       (ctl),
        .addr      (otp_addr),
        .dout      (otp_dout)
    );

    assign otp_clk    = ctl.clk;
    assign otp_ce     = ctl.ce;
    assign otp_trim   = ctl.trim;
    assign otp_stby_n = ctl.stby_n;
endmodule

// File: rtl/fuse_rd_chk.sv
module fuse_rd_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 12,
    parameter int HI_CYC = 40
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input logic [ADDR_W-1:0] otp_addr,
    input logic              otp_clk,
    input logic              otp_ce,
    input logic              otp_trim,
    input logic              otp_stby_n
);
    int hi_len;

    always_ff @(posedge clk) begin
        if (rst)
            hi_len <= 0;
        else if (otp_clk)
            hi_len <= hi_len + 1;
        else
            hi_len <= 0;
    end

    a_r3_trim_awake: assert property (@(posedge clk) disable iff (rst)
        otp_trim |-> otp_stby_n);

    a_r3_ce_after_trim: assert property (@(posedge clk) disable iff (rst)
        otp_ce |-> otp_trim);

    a_r4_clk_enabled: assert property (@(posedge clk) disable iff (rst)
        otp_clk |-> otp_ce);

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        otp_clk |-> $stable(otp_addr));

    a_r4_high_width: assert property (@(posedge clk) disable iff (rst)
        $fell(otp_clk) |-> hi_len == HI_CYC);

    a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r7_no_pulse_pending: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !otp_clk);

    a_r1_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> (done && !busy));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !otp_stby_n));
endmodule

bind fuse_rd_seq fuse_rd_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .HI_CYC (T_ACC_US * CLKS_PER_US)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .otp_addr   (otp_addr),
    .otp_clk    (otp_clk),
    .otp_ce     (otp_ce),
    .otp_trim   (otp_trim),
    .otp_stby_n (otp_stby_n)
);

// File: tb/tb_fuse_rd_seq.sv
module tb_fuse_rd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CPU   = 2;
    localparam int HI    = 40 * CPU;
    localparam int LO    = 10 * CPU;
    localparam int TOTAL = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [12:0] req_idx = '0;
    logic [12:0] req_cnt = '0;
    logic        busy, done, err, out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [11:0] otp_addr;
    logic        otp_clk, otp_ce, otp_trim, otp_stby_n;
    logic [31:0] otp_dout = '0;

    int nchk = 0;
    int nerr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fuse_rd_seq #(.CLKS_PER_US(CPU), .TOTAL_FUSES(TOTAL)) dut (
        .clk(clk), .rst(rst), .start(start), .req_idx(req_idx), .req_cnt(req_cnt),
        .busy(busy), .done(done), .err(err), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .otp_addr(otp_addr),
        .otp_clk(otp_clk), .otp_ce(otp_ce), .otp_trim(otp_trim),
        .otp_stby_n(otp_stby_n), .otp_dout(otp_dout)
    );

    function automatic logic [31:0] fuse_val(input logic [11:0] a);
        return {a, 8'h5C, ~a};
    endfunction

    // fuse array model: data follows the address on each macro clock rise
    always @(posedge otp_clk) otp_dout <= fuse_val(otp_addr);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // pin monitor
    int       cyc = 0;
    int       t_su = -100, t_tu = -100, t_cd = -100, t_td = -100;
    int       hi_w = 0, lo_w = 1000;
    int       exp_addr = 0;
    logic     p_stby = 0, p_trim = 0, p_ce = 0, p_clk = 0, p_valid = 0;
    logic [11:0] p_addr = '0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (otp_stby_n && !p_stby) t_su = cyc;
            if (otp_trim && !p_trim) t_tu = cyc;
            if (otp_ce && !p_ce)
                chk(t_tu == cyc-1 && t_su == cyc-2, "R3 wake order", 64'(cyc - t_tu), 64'd1);
            if (!otp_ce && p_ce) t_cd = cyc;
            if (!otp_trim && p_trim) t_td = cyc;
            if (!otp_stby_n && p_stby)
                chk(t_td == cyc-1 && t_cd == cyc-2 && done, "R8 sleep order", 64'(cyc - t_cd), 64'd2);
            if (otp_clk && !p_clk) begin
                chk(otp_addr == 12'(exp_addr) && otp_addr == p_addr && otp_ce && otp_trim && otp_stby_n,
                    "R6 address at clock rise", 64'(otp_addr), 64'(exp_addr));
                chk(lo_w >= LO, "R5 low gap", 64'(lo_w), 64'(LO));
                exp_addr++;
                hi_w = 1;
            end else if (otp_clk) begin
                hi_w++;
                chk(otp_addr == p_addr, "R4 address hold", 64'(otp_addr), 64'(p_addr));
            end
            if (!otp_clk && p_clk) begin
                chk(hi_w == HI, "R4 high width", 64'(hi_w), 64'(HI));
                lo_w = 1;
            end else if (!otp_clk) begin
                lo_w++;
            end
            // valid rises on the edge after LO low cycles: LO low samples plus this one
            if (out_valid && !p_valid)
                chk(lo_w == LO + 1, "R5 capture after low phase", 64'(lo_w), 64'(LO + 1));
        end
        p_stby = otp_stby_n; p_trim = otp_trim; p_ce = otp_ce;
        p_clk = otp_clk; p_valid = out_valid; p_addr = otp_addr;
    end

    task automatic t_reset();
        chk(!busy && !done && !err && !out_valid, "R10 status after reset",
            64'({busy, done, err, out_valid}), 64'd0);
        chk(!otp_clk && !otp_ce && !otp_trim && !otp_stby_n && otp_addr == '0,
            "R10 macro pins after reset", 64'({otp_clk, otp_ce, otp_trim, otp_stby_n}), 64'd0);
    endtask

    task automatic run_read(input int idx, input int cnt, input int stall_word, input bit poke);
        int  words = 0;
        int  guard = 0;
        bit  stalled = 0;
        bit  poked = 0;
        exp_addr  = idx;
        out_ready = (stall_word != 0);
        @(negedge clk);
        start = 1; req_idx = 13'(idx); req_cnt = 13'(cnt);
        @(negedge clk);
        start = 0;
        chk(busy, "R9 busy after start", 64'(busy), 64'd1);
        while (!done && guard < 20000) begin
            if (out_valid && out_ready) begin
                chk(out_data == fuse_val(12'(idx + words)), "R5 word value",
                    64'(out_data), 64'(fuse_val(12'(idx + words))));
                words++;
            end
            if (start) begin
                start = 0;
            end else if (poke && otp_clk && !poked) begin
                // R9: a second request while busy must be ignored
                start = 1; req_idx = 13'd0; req_cnt = 13'd1;
                poked = 1;
            end
            if (out_valid && !out_ready && words == stall_word && !stalled) begin
                logic [31:0] held_d;
                logic [11:0] held_a;
                held_d = out_data;
                held_a = otp_addr;
                repeat (30) begin
                    @(negedge clk);
                    chk(out_valid && out_data == held_d && !otp_clk && otp_addr == held_a,
                        "R7 stall hold", 64'(out_data), 64'(held_d));
                end
                out_ready = 1;
                stalled = 1;
            end else begin
                out_ready = stalled || (words != stall_word);
            end
            @(negedge clk);
            guard++;
        end
        start = 0;
        out_ready = 1;
        chk(done && !err && !busy, "R9 done pulse idle", 64'({done, err, busy}), 64'b100);
        chk(words == cnt, "R6 word count", 64'(words), 64'(cnt));
        chk(exp_addr == idx + cnt, "R6 address run end", 64'(exp_addr), 64'(idx + cnt));
        chk(!otp_ce && !otp_trim && !otp_stby_n, "R8 macro asleep",
            64'({otp_ce, otp_trim, otp_stby_n}), 64'd0);
        @(negedge clk);
        chk(!done, "R9 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic quick_req(input int idx, input int cnt, input bit exp_err, input string tag);
        logic [11:0] a0;
        a0 = otp_addr;
        @(negedge clk);
        start = 1; req_idx = 13'(idx); req_cnt = 13'(cnt);
        @(negedge clk);
        start = 0;
        chk(done && err == exp_err && !busy, tag, 64'({done, err, busy}), 64'({1'b1, exp_err, 1'b0}));
        repeat (4) begin
            @(negedge clk);
            chk(!busy && !done && !otp_stby_n && !otp_trim && !otp_ce && !otp_clk && otp_addr == a0,
                tag, 64'({busy, otp_stby_n, otp_trim, otp_ce, otp_clk}), 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        run_read(10, 3, -1, 0);
        run_read(TOTAL - 1, 1, -1, 0);
        run_read(100, 3, 1, 0);
        run_read(200, 3, -1, 1);
        quick_req(TOTAL - 1, 2, 1, "R1 span past end");
        quick_req(TOTAL, 1, 1, "R1 index past end");
        quick_req(50, 0, 0, "R2 empty request");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule